// File: doc/BRIEF.md
# Polled Serial Port Register Front End

This block is the register face of a simple polled serial port. A host reaches three 32-bit registers over a plain bus made of an address, a write strobe, write data and read data. The data register carries one received byte and one byte waiting to go out, each marked by a flag bit. The control register holds the interface mode, two ready overrides and a sticky overrun bit. The clock register holds the scale and step values that a separate baud generator uses.

On the serial side the block passes its pending byte to a transmit shifter through a byte, valid and ready handshake. It takes bytes from a receive shifter through a byte and valid pair. A flow-control input from the far end gates transmission, and an output tells the far end whether a byte can be accepted. Each of these two conditions can be forced by an override bit. Reads are combinational from the current register state. Writes take effect at the next rising clock edge.

Top module: `serial_reg_front`

## Requirements
- R1: Registers sit at byte offsets 0x00 (data), 0x04 (control) and 0x08 (clock). Any other address reads zero and writes to it change nothing. Bits without a function read zero and ignore writes. In the clock register those are bits 31:28. In the control register every bit except 3:2, 7, 8 and 12 reads zero.
- R2: When a byte arrives on the receive pair while no byte is held, data register bit 8 reads 1 and bits 7:0 read that byte. Bits 7:0 read zero while bit 8 is 0.
- R3: A write to the data register with bit 8 set clears bit 8. A byte arriving in the same cycle is then captured.
- R4: Data register bit 9 reads 1 when the transmit holding slot is empty. A data write with bit 9 set fills the slot with bits 7:0. Bit 9 then reads 0 until the transmit shifter accepts the byte through valid and ready both high in one cycle.
- R5: A data write with bit 9 clear does not fill the transmit slot and does not raise the transmit valid output.
- R6: A data write with bit 9 set while the slot is full is ignored, and the byte already held keeps being offered.
- R7: Control bits 3:2 store the interface mode (1 = DTE, 2 = DCE) and drive the mode output unchanged.
- R8: Transmit valid rises only while a byte is held and either the flow-control input is high or control bit 7 (transmit override) is set. The local-ready output is high when no received byte is held or control bit 8 (receive override) is set.
- R9: A byte that arrives while a received byte is still held is dropped. The held byte is kept and control bit 12 (overrun) is set. Writing 1 to bit 12 clears it, and writing 0 leaves it set.
- R10: Clock register bits 27:16 (scale, 12 bits) and bits 15:0 (step, 16 bits) are stored and drive the baud outputs unchanged.
- R11: After reset, data reads 0x200, control and clock read zero, transmit valid is low and local-ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| txq_byte | output | 8 | Byte offered to the transmit shifter |
| txq_valid | output | 1 | Byte offered |
| txq_ready | input | 1 | Transmit shifter takes the byte |
| rxq_byte | input | 8 | Byte from the receive shifter |
| rxq_valid | input | 1 | One-cycle pulse: byte delivered |
| peer_ready | input | 1 | Flow-control input from the far end |
| local_ready | output | 1 | Flow-control output to the far end |
| link_mode | output | 2 | Interface mode field |
| baud_scale | output | 12 | Scale for the baud generator |
| baud_step | output | 16 | Step for the baud generator |

## Verification
The assertions assume that rxq_valid is a pulse paired with a stable byte. They also assume that txq_ready is honoured only while txq_valid is high, so an acceptance outside an offer has no effect and is never relied on. The stimulus raises every input at a falling edge for exactly one cycle. It raises txq_ready only while a byte is offered, and it delivers receive bytes only when a check is prepared for them. Register writes stay on the clock edge that follows the write strobe, so each readback comes one cycle after its write.

// File: rtl/serial_front_pkg.sv
package serial_front_pkg;
  localparam int BUS_W        = 32;
  localparam int BYTE_W       = 8;
  localparam int SCALE_W      = 12;
  localparam int STEP_W       = 16;
  localparam int MODE_W       = 2;

  localparam int OFS_DATA     = 'h0;
  localparam int OFS_CTRL     = 'h4;
  localparam int OFS_CLK      = 'h8;

  localparam int DAT_RXF      = 8;
  localparam int DAT_TXF      = 9;
  localparam int CTL_MODE_LO  = 2;
  localparam int CTL_TXOVR    = 7;
  localparam int CTL_RXOVR    = 8;
  localparam int CTL_OVRUN    = 12;
  localparam int CLK_SCALE_LO = 16;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic              tx_ovr;
    logic              rx_ovr;
    logic              overrun;
  } ctrl_t;

  function automatic logic [BUS_W-1:0] pack_data(input logic rx_full,
                                                 input logic tx_free,
                                                 input logic [BYTE_W-1:0] rx_byte);
    logic [BUS_W-1:0] v;
    v = '0;
    v[DAT_TXF] = tx_free;
    v[DAT_RXF] = rx_full;
    if (rx_full) v[BYTE_W-1:0] = rx_byte;
    return v;
  endfunction

  function automatic logic [BUS_W-1:0] pack_ctrl(input ctrl_t c);
    logic [BUS_W-1:0] v;
    v = '0;
    v[CTL_MODE_LO +: MODE_W] = c.mode;
    v[CTL_TXOVR] = c.tx_ovr;
    v[CTL_RXOVR] = c.rx_ovr;
    v[CTL_OVRUN] = c.overrun;
    return v;
  endfunction

  function automatic logic [BUS_W-1:0] pack_clk(input logic [SCALE_W-1:0] scale,
                                                input logic [STEP_W-1:0] step);
    logic [BUS_W-1:0] v;
    v = '0;
    v[CLK_SCALE_LO +: SCALE_W] = scale;
    v[STEP_W-1:0] = step;
    return v;
  endfunction
endpackage

// File: rtl/sfr_tx_hold.sv
module sfr_tx_hold #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_req,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              peer_ok,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              slot_free
);
  logic              pend;
  logic [BYTE_W-1:0] hold;
  logic              accept_evt;
  logic              load_evt;

  assign tx_valid   = pend & peer_ok;
  assign accept_evt = tx_valid & tx_ready;
  assign load_evt   = load_req & ~pend;
  assign tx_byte    = hold;
  assign slot_free  = ~pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      hold <= '0;
    end else begin
      if (accept_evt) pend <= 1'b0;
      if (load_evt) begin
        pend <= 1'b1;
        hold <= load_byte;
      end
    end
  end

  AST_TX_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    load_req && slot_free |=> !slot_free && tx_byte == $past(load_byte)); // R4
  AST_TX_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    !load_req && slot_free |=> slot_free); // R5
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_free && !accept_evt |=> !slot_free && $stable(tx_byte)); // R6
endmodule

// File: rtl/sfr_rx_hold.sv
module sfr_rx_hold #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              ack,
  output logic              full,
  output logic [BYTE_W-1:0] held_byte,
  output logic              overrun_evt
);
  logic [BYTE_W-1:0] hold;
  logic              busy_after_ack;
  logic              take_evt;

  assign busy_after_ack = full & ~ack;
  assign take_evt       = rx_valid & ~busy_after_ack;
  assign overrun_evt    = rx_valid & busy_after_ack;
  assign held_byte      = hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      hold <= '0;
    end else begin
      if (ack) full <= 1'b0;
      if (take_evt) begin
        full <= 1'b1;
        hold <= rx_byte;
      end
    end
  end

  AST_RX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !full |=> full && held_byte == $past(rx_byte)); // R2
  AST_RX_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !rx_valid |=> !full); // R3
  AST_RX_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    full && !ack |=> full && $stable(held_byte)); // R9
endmodule

// File: rtl/sfr_ctrl_reg.sv
module sfr_ctrl_reg
  import serial_front_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [BUS_W-1:0] wdata,
  input  logic             overrun_evt,
  output ctrl_t            ctrl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else begin
      if (wr) begin
        ctrl.mode   <= wdata[CTL_MODE_LO +: MODE_W];
        ctrl.tx_ovr <= wdata[CTL_TXOVR];
        ctrl.rx_ovr <= wdata[CTL_RXOVR];
        if (wdata[CTL_OVRUN]) ctrl.overrun <= 1'b0;
      end
      if (overrun_evt) ctrl.overrun <= 1'b1;
    end
  end

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.overrun && !(wr && wdata[CTL_OVRUN]) |=> ctrl.overrun); // R9
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_evt |=> ctrl.overrun); // R9
endmodule

// File: rtl/sfr_clk_reg.sv
module sfr_clk_reg
  import serial_front_pkg::*;
#(
  parameter int SC_W = SCALE_W,
  parameter int ST_W = STEP_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [SC_W-1:0] scale_in,
  input  logic [ST_W-1:0] step_in,
  output logic [SC_W-1:0] scale,
  output logic [ST_W-1:0] step
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scale <= '0;
      step  <= '0;
    end else if (wr) begin
      scale <= scale_in;
      step  <= step_in;
    end
  end

  AST_CLK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(scale) && $stable(step)); // R10
endmodule

// File: rtl/serial_reg_front.sv
module serial_reg_front
  import serial_front_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  output logic [BYTE_W-1:0]  txq_byte,
  output logic               txq_valid,
  input  logic               txq_ready,
  input  logic [BYTE_W-1:0]  rxq_byte,
  input  logic               rxq_valid,
  input  logic               peer_ready,
  output logic               local_ready,
  output logic [MODE_W-1:0]  link_mode,
  output logic [SCALE_W-1:0] baud_scale,
  output logic [STEP_W-1:0]  baud_step
);
  logic              hit_data, hit_ctrl, hit_clk;
  logic              wr_data, wr_ctrl, wr_clk;
  logic              tx_free, rx_full, overrun_evt;
  logic [BYTE_W-1:0] rx_held;
  ctrl_t             ctrl;
  logic              unused_wbits;

  assign hit_data = bus_addr == ADDR_W'(OFS_DATA);
  assign hit_ctrl = bus_addr == ADDR_W'(OFS_CTRL);
  assign hit_clk  = bus_addr == ADDR_W'(OFS_CLK);
  assign wr_data  = bus_we & hit_data;
  assign wr_ctrl  = bus_we & hit_ctrl;
  assign wr_clk   = bus_we & hit_clk;
  assign unused_wbits = ^bus_wdata[BUS_W-1:CLK_SCALE_LO+SCALE_W];

  sfr_tx_hold #(.BYTE_W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .load_req(wr_data & bus_wdata[DAT_TXF]),
    .load_byte(bus_wdata[BYTE_W-1:0]),
    .peer_ok(peer_ready | ctrl.tx_ovr),
    .tx_ready(txq_ready), .tx_valid(txq_valid),
    .tx_byte(txq_byte), .slot_free(tx_free)
  );

  sfr_rx_hold #(.BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rxq_valid), .rx_byte(rxq_byte),
    .ack(wr_data & bus_wdata[DAT_RXF]),
    .full(rx_full), .held_byte(rx_held), .overrun_evt(overrun_evt)
  );

  sfr_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(wr_ctrl), .wdata(bus_wdata),
    .overrun_evt(overrun_evt), .ctrl(ctrl)
  );

  sfr_clk_reg #(.SC_W(SCALE_W), .ST_W(STEP_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .wr(wr_clk),
    .scale_in(bus_wdata[CLK_SCALE_LO +: SCALE_W]),
    .step_in(bus_wdata[STEP_W-1:0]),
    .scale(baud_scale), .step(baud_step)
  );

  assign local_ready = ~rx_full | ctrl.rx_ovr;
  assign link_mode   = ctrl.mode;

  always_comb begin
    unique case (1'b1)
      hit_data: bus_rdata = pack_data(rx_full, tx_free, rx_held);
      hit_ctrl: bus_rdata = pack_ctrl(ctrl);
      hit_clk:  bus_rdata = pack_clk(baud_scale, baud_step);
      default:  bus_rdata = '0;
    endcase
  end

  AST_TX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    txq_valid |-> (peer_ready || ctrl.tx_ovr) && !tx_free); // R8
  AST_RX_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.rx_ovr |-> local_ready); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_data || hit_ctrl || hit_clk) |-> bus_rdata == '0); // R1
  AST_MODE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> link_mode == $past(bus_wdata[CTL_MODE_LO +: MODE_W])); // R7
endmodule

// File: tb/sim_serial_reg_front.sv
module sim_serial_reg_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  txq_byte;
  logic        txq_valid;
  logic        txq_ready = 1'b0;
  logic [7:0]  rxq_byte = '0;
  logic        rxq_valid = 1'b0;
  logic        peer_ready = 1'b0;
  logic        local_ready;
  logic [1:0]  link_mode;
  logic [11:0] baud_scale;
  logic [15:0] baud_step;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  serial_reg_front u0 (.*);

  // {addr, write value, expected readback}
  localparam logic [67:0] VEC [6] = '{
    {4'h8, 32'hFFFF_FFFF, 32'h0FFF_FFFF},
    {4'h8, 32'h1234_5678, 32'h0234_5678},
    {4'h4, 32'hFFFF_FFFF, 32'h0000_018C},
    {4'h4, 32'h0000_0008, 32'h0000_0008},
    {4'h4, 32'h0000_0004, 32'h0000_0004},
    {4'hC, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  function automatic logic [31:0] data_word(bit rx_flag, bit tx_free, logic [7:0] b);
    return {22'd0, tx_free, rx_flag, rx_flag ? b : 8'h00};
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic rx_pulse(logic [7:0] b);
    @(negedge clk);
    rxq_valid = 1'b1; rxq_byte = b;
    @(negedge clk);
    rxq_valid = 1'b0;
  endtask

  task automatic tx_accept();
    @(negedge clk);
    txq_ready = 1'b1;
    @(negedge clk);
    txq_ready = 1'b0;
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(4'h0, r); chk("R11 data after reset", r, 32'h200);
    rd(4'h4, r); chk("R11 ctrl after reset", r, 32'h0);
    rd(4'h8, r); chk("R11 clk after reset", r, 32'h0);
    chk("R11 txq_valid after reset", {31'd0, txq_valid}, 32'd0);
    chk("R11 local_ready after reset", {31'd0, local_ready}, 32'd1);

    for (int i = 0; i < 6; i++) begin
      wr(VEC[i][67:64], VEC[i][63:32]);
      rd(VEC[i][67:64], r);
      chk($sformatf("R1/R7/R10 vector %0d readback", i), r, VEC[i][31:0]);
    end
    chk("R7 link_mode output", {30'd0, link_mode}, 32'd1);
    chk("R10 baud_scale output", {20'd0, baud_scale}, 32'h234);
    chk("R10 baud_step output", {16'd0, baud_step}, 32'h5678);
    wr(4'h4, 32'h0);

    peer_ready = 1'b1;
    wr(4'h0, 32'h0000_0041);
    chk("R5 no transmit on bit9 clear", {31'd0, txq_valid}, 32'd0);
    rd(4'h0, r); chk("R5 slot still free", r, data_word(0, 1, 8'h00));

    wr(4'h0, 32'h0000_02A5);
    chk("R4 txq_valid raised", {31'd0, txq_valid}, 32'd1);
    chk("R4 txq_byte", {24'd0, txq_byte}, 32'hA5);
    rd(4'h0, r); chk("R4 bit9 low while pending", r, data_word(0, 0, 8'h00));
    tx_accept();
    chk("R4 txq_valid dropped after accept", {31'd0, txq_valid}, 32'd0);
    rd(4'h0, r); chk("R4 bit9 high after accept", r, data_word(0, 1, 8'h00));

    wr(4'h0, 32'h0000_0211);
    wr(4'h0, 32'h0000_0222);
    chk("R6 first byte kept", {24'd0, txq_byte}, 32'h11);
    tx_accept();

    peer_ready = 1'b0;
    wr(4'h0, 32'h0000_0233);
    chk("R8 no valid without peer ready", {31'd0, txq_valid}, 32'd0);
    wr(4'h4, 32'h0000_0080);
    chk("R8 tx override raises valid", {31'd0, txq_valid}, 32'd1);
    chk("R8 overridden byte", {24'd0, txq_byte}, 32'h33);
    tx_accept();
    wr(4'h4, 32'h0);

    rx_pulse(8'h5C);
    rd(4'h0, r); chk("R2 received byte and flag", r, data_word(1, 1, 8'h5C));
    chk("R8 local_ready low when full", {31'd0, local_ready}, 32'd0);

    rx_pulse(8'h77);
    rd(4'h0, r); chk("R9 old byte kept", r, data_word(1, 1, 8'h5C));
    rd(4'h4, r); chk("R9 overrun set", r, 32'h1000);
    wr(4'h4, 32'h0);
    rd(4'h4, r); chk("R9 overrun survives write of 0", r, 32'h1000);
    wr(4'h4, 32'h1000);
    rd(4'h4, r); chk("R9 overrun cleared by write of 1", r, 32'h0);

    wr(4'h4, 32'h0000_0100);
    chk("R8 rx override forces local_ready", {31'd0, local_ready}, 32'd1);
    wr(4'h4, 32'h0);

    wr(4'h0, 32'h0000_0100);
    rd(4'h0, r); chk("R3 ack clears flag", r, data_word(0, 1, 8'h00));
    chk("R3 ack starts no transmit", {31'd0, txq_valid}, 32'd0);

    rx_pulse(8'h0F);
    @(negedge clk);
    bus_addr = 4'h0; bus_we = 1'b1; bus_wdata = 32'h100;
    rxq_valid = 1'b1; rxq_byte = 8'hE1;
    @(negedge clk);
    bus_we = 1'b0; rxq_valid = 1'b0;
    rd(4'h0, r); chk("R3 same-cycle ack and arrival", r, data_word(1, 1, 8'hE1));
    rd(4'h4, r); chk("R9 no overrun on same-cycle ack", r, 32'h0);

    wr(4'hC, 32'h0000_0301);
    rd(4'h0, r); chk("R1 unmapped write has no effect", r, data_word(1, 1, 8'hE1));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule